// File: doc/BRIEF.md
# Two-Level Lookahead Adder/Subtractor Section

This block is a purely combinational 16-bit two-operand adder/subtractor. It is built from four 4-bit groups. Each group forms a generate and a propagate signal for every bit, works out its own internal carries by lookahead, and reports a group generate and a group propagate. A second-level lookahead carry unit takes those group signals and the forced carry. It produces the carry into groups 1, 2 and 3 directly, so no carry ripples from one group to the next.

The block also reports a section generate and a section propagate that cover all 16 bits. Four of these sections can therefore be joined under a further lookahead level to make a 64-bit adder. For subtraction, the block complements the second operand and flips the sense of the incoming carry. With the carry input low, this forms X minus Y. With the carry input high, it forms X minus Y minus 1, which lets a borrow chain across sections.

Top module: `cla_section_addsub`

## Requirements
- R1: With `sub_i`=0, `sum_o` equals the low 16 bits of X + Y + `cin_i`, and `cout_o` equals bit 16 of that sum.
- R2: With `sub_i`=1, the operand used is the bitwise complement of Y, and the forced carry is the inverse of `cin_i`. So `sum_o` is X − Y when `cin_i`=0 and X − Y − 1 when `cin_i`=1, and `cout_o` is 1 exactly when no borrow occurs.
- R3: `sect_prop_o` is 1 exactly when every one of the 16 bit positions has x OR y' equal to 1, where y' is the operand after the optional complement.
- R4: `sect_gen_o` is 1 exactly when X + y' with a zero forced carry overflows 16 bits, and `cout_o` always equals `sect_gen_o` OR (`sect_prop_o` AND the forced carry).
- R5: All-ones plus 0x0001 in add mode gives `sum_o`=0x0000 and `cout_o`=1, with the carry crossing every group.
- R6: The carry into each of groups 1 to 3 (bits 4, 8 and 12) comes from the second-level unit. It equals the carry-out that the group below would produce from its own generate, its own propagate and its own carry-in.
- R7: A group generate is 1 when the group overflows with a zero carry-in. A group propagate is 1 when every bit of the group has x OR y' set.
- R8: Subtracting 0x0002 from 0x0005 with `cin_i`=0 gives 0x0003 with `cout_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 16 | First operand |
| y_i | input | 16 | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | 1 selects subtraction |
| cin_i | input | 1 | Carry in for add; borrow in for subtract |
| sum_o | output | 16 | Result |
| cout_o | output | 1 | Carry out of bit 15 (1 = no borrow when subtracting) |
| sect_gen_o | output | 1 | Section generate over all 16 bits |
| sect_prop_o | output | 1 | Section propagate over all 16 bits |

## Verification
The in-line checks assume that the operand, mode and carry inputs are settled, known values whenever the combinational checks evaluate. They also assume that the only carry into the section is the one derived from the carry input and the mode. The stimulus changes all inputs together once per cycle and never drives X or Z. It covers groups that generate, groups that propagate and groups that kill, in both modes and with both carry-input values. The checks are then made half a cycle later, when every lookahead path has settled.

// File: rtl/cla_pkg.sv
package cla_pkg;
   localparam int MAX_SPAN = 64;

   // AND of p[lo..hi]; empty range yields 1
   function automatic logic span_and(input logic [MAX_SPAN-1:0] p, input int lo, input int hi);
      logic r;
      r = 1'b1;
      for (int k = 0; k < MAX_SPAN; k++) begin
         if (k >= lo && k <= hi) r = r & p[k];
      end
      return r;
   endfunction

   // Sum-of-products lookahead carry out of position 'top'
   function automatic logic la_carry(input logic [MAX_SPAN-1:0] g,
                                     input logic [MAX_SPAN-1:0] p,
                                     input logic cin, input int top);
      logic acc;
      acc = cin & span_and(p, 0, top);
      for (int j = 0; j < MAX_SPAN; j++) begin
         if (j <= top) acc = acc | (g[j] & span_and(p, j + 1, top));
      end
      return acc;
   endfunction
endpackage

// File: rtl/cla_carry_net.sv
module cla_carry_net
   import cla_pkg::*;
#(
   parameter int SPAN = 4
) (
   input  logic [SPAN-1:0] gen_i,
   input  logic [SPAN-1:0] prop_i,
   input  logic            cin_i,
   output logic [SPAN:0]   carry_o,
   output logic            blk_gen_o,
   output logic            blk_prop_o
);
   localparam int LAST = SPAN - 1;

   if (SPAN < 1 || SPAN > MAX_SPAN) begin : g_bad_span
      $error("cla_carry_net: SPAN out of range");
   end

   logic [MAX_SPAN-1:0] g_ext, p_ext;
   assign g_ext = MAX_SPAN'(gen_i);
   assign p_ext = MAX_SPAN'(prop_i);

   assign carry_o[0] = cin_i;
   for (genvar i = 0; i < SPAN; i++) begin : g_carry
      always_comb carry_o[i+1] = la_carry(g_ext, p_ext, cin_i, i);
   end

   always_comb blk_gen_o  = la_carry(g_ext, p_ext, 1'b0, LAST);
   always_comb blk_prop_o = span_and(p_ext, 0, LAST);

   // R4: the top carry must agree with block generate/propagate
   always_comb begin
      assert_blk_carry_R4: assert (carry_o[SPAN] == (blk_gen_o | (blk_prop_o & cin_i)))
         else $error("carry net top carry disagrees with block gen/prop");
   end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
   parameter int GW = 4
) (
   input  logic [GW-1:0] a_i,
   input  logic [GW-1:0] b_i,
   input  logic          cin_i,
   output logic [GW-1:0] sum_o,
   output logic          grp_gen_o,
   output logic          grp_prop_o
);
   if (GW < 1) begin : g_bad_gw
      $error("cla_group: GW must be positive");
   end

   logic [GW-1:0] bit_gen, bit_prop;
   logic [GW:0]   carry;

   always_comb begin
      bit_gen  = a_i & b_i;
      bit_prop = a_i | b_i;
   end

   cla_carry_net #(.SPAN(GW)) u_net (
      .gen_i     (bit_gen),
      .prop_i    (bit_prop),
      .cin_i     (cin_i),
      .carry_o   (carry),
      .blk_gen_o (grp_gen_o),
      .blk_prop_o(grp_prop_o)
   );

   always_comb sum_o = a_i ^ b_i ^ carry[GW-1:0];

   // R7: group generate equals the overflow seen with zero carry-in
   always_comb begin
      if (!cin_i) begin
         assert_grp_gen_R7: assert (grp_gen_o == carry[GW])
            else $error("group generate mismatch");
      end
      assert_grp_prop_R7: assert (grp_prop_o == (&(a_i | b_i)))
         else $error("group propagate mismatch");
   end
endmodule

// File: rtl/cla_section_addsub.sv
module cla_section_addsub #(
   parameter int GROUP_W    = 4,
   parameter int NUM_GROUPS = 4,
   parameter bit RIPPLE_GRP = 1'b0,
   localparam int WIDTH     = GROUP_W * NUM_GROUPS
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             sub_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             sect_gen_o,
   output logic             sect_prop_o
);
   if (GROUP_W < 1 || NUM_GROUPS < 1) begin : g_bad_cfg
      $error("cla_section_addsub: sizes must be positive");
   end

   logic [WIDTH-1:0]      y_eff;
   logic                  c0;
   logic [NUM_GROUPS-1:0] grp_gen, grp_prop;
   logic [NUM_GROUPS:0]   grp_cin;

   always_comb begin
      y_eff = y_i ^ {WIDTH{sub_i}};
      c0    = cin_i ^ sub_i;
   end

   for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_grp
      cla_group #(.GW(GROUP_W)) u_grp (
         .a_i       (x_i  [k*GROUP_W +: GROUP_W]),
         .b_i       (y_eff[k*GROUP_W +: GROUP_W]),
         .cin_i     (grp_cin[k]),
         .sum_o     (sum_o[k*GROUP_W +: GROUP_W]),
         .grp_gen_o (grp_gen[k]),
         .grp_prop_o(grp_prop[k])
      );
   end

   if (RIPPLE_GRP) begin : g_ripple
      assign grp_cin[0] = c0;
      for (genvar k = 0; k < NUM_GROUPS; k++) begin : g_link
         assign grp_cin[k+1] = grp_gen[k] | (grp_prop[k] & grp_cin[k]);
      end
      always_comb sect_gen_o  = cla_pkg::la_carry(cla_pkg::MAX_SPAN'(grp_gen),
                                                  cla_pkg::MAX_SPAN'(grp_prop), 1'b0, NUM_GROUPS - 1);
      always_comb sect_prop_o = &grp_prop;
   end else begin : g_lookahead
      cla_carry_net #(.SPAN(NUM_GROUPS)) u_lcu (
         .gen_i     (grp_gen),
         .prop_i    (grp_prop),
         .cin_i     (c0),
         .carry_o   (grp_cin),
         .blk_gen_o (sect_gen_o),
         .blk_prop_o(sect_prop_o)
      );
   end

   always_comb cout_o = sect_gen_o | (sect_prop_o & c0);

   // R6: each group's carry-in matches the carry-out of the group below
   // R4: carry out agrees with the carry unit's final carry
   always_comb begin
      for (int k = 0; k < NUM_GROUPS; k++) begin
         assert_grp_link_R6: assert (grp_cin[k+1] == (grp_gen[k] | (grp_prop[k] & grp_cin[k])))
            else $error("group carry-in %0d inconsistent", k + 1);
      end
      assert_cout_R4: assert (cout_o == grp_cin[NUM_GROUPS])
         else $error("carry out disagrees with final group carry");
      assert_cin_R2: assert (grp_cin[0] == (cin_i ^ sub_i))
         else $error("forced carry wrong for mode");
   end
endmodule

// File: tb/cla_section_addsub_tb.sv
module cla_section_addsub_tb;
   localparam int W = 16;

   typedef struct {
      logic [W-1:0] sum;
      logic         cout;
      logic         gen;
      logic         prop;
      string        tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] x, y, sum;
   logic sub, cin, cout, sgen, sprop;
   int n_vec = 0, n_bad = 0, cycles = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;  // 50 MHz

   cla_section_addsub u_dut (
      .x_i(x), .y_i(y), .sub_i(sub), .cin_i(cin),
      .sum_o(sum), .cout_o(cout), .sect_gen_o(sgen), .sect_prop_o(sprop)
   );

   task automatic apply(input logic [W-1:0] xa, input logic [W-1:0] ya,
                        input logic s, input logic c, input string tag);
      exp_t e;
      logic [W-1:0] ye;
      logic [W:0] full, raw;
      @(posedge clk);
      x = xa; y = ya; sub = s; cin = c;
      ye   = s ? ~ya : ya;
      full = {1'b0, xa} + {1'b0, ye} + {{W{1'b0}}, c ^ s};
      raw  = {1'b0, xa} + {1'b0, ye};
      e.sum = full[W-1:0];
      e.cout = full[W];
      e.gen = raw[W];
      e.prop = &(xa | ye);
      e.tag = tag;
      q.push_back(e);
   endtask

   always @(negedge clk) begin
      if (!rst && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_vec++;
         if (sum !== e.sum || cout !== e.cout || sgen !== e.gen || sprop !== e.prop) begin
            n_bad++;
            $display("FAIL %s (sum/cout R1 R2, gen R4, prop R3): got %h/%b/%b/%b exp %h/%b/%b/%b",
                     e.tag, sum, cout, sgen, sprop, e.sum, e.cout, e.gen, e.prop);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         done = 1'b1;
         n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      x = '0; y = '0; sub = 1'b0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      apply(16'h0000, 16'h0000, 1'b0, 1'b0, "R1 reset-state zero");
      apply(16'h1234, 16'h4321, 1'b0, 1'b0, "R1 add");
      apply(16'h1234, 16'h4321, 1'b0, 1'b1, "R1 add cin");
      apply(16'hFFFF, 16'h0001, 1'b0, 1'b0, "R5 full ripple");
      apply(16'hFFFF, 16'h0000, 1'b0, 1'b1, "R5 cin through all");
      apply(16'h0005, 16'h0002, 1'b1, 1'b0, "R8 subtract");
      apply(16'h0002, 16'h0005, 1'b1, 1'b0, "R2 borrow");
      apply(16'h0005, 16'h0002, 1'b1, 1'b1, "R2 borrow-in");
      apply(16'h000F, 16'h0001, 1'b0, 1'b0, "R6 group0->1");
      apply(16'h00F0, 16'h0010, 1'b0, 1'b0, "R6 group1->2");
      apply(16'h0F00, 16'h0100, 1'b0, 1'b0, "R6 group2->3");
      apply(16'h0FFF, 16'h0001, 1'b0, 1'b0, "R6 chained groups");
      apply(16'h0008, 16'h0008, 1'b0, 1'b0, "R7 group generate");
      apply(16'h000A, 16'h0005, 1'b0, 1'b1, "R7 group propagate");
      apply(16'hAAAA, 16'h5555, 1'b0, 1'b0, "R3 all propagate");
      apply(16'hAAAA, 16'h5555, 1'b0, 1'b1, "R4 propagate with carry");
      apply(16'h8000, 16'h8000, 1'b0, 1'b0, "R4 top generate");
      apply(16'h1234, 16'h1234, 1'b1, 1'b0, "R2 equal operands");
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] ra, rb;
         logic [1:0] m;
         ra = W'($urandom);
         rb = W'($urandom);
         m  = 2'($urandom);
         apply(ra, rb, m[0], m[1], m[0] ? "R2 random sub" : "R1 random add");
      end
      repeat (3) @(posedge clk);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R1 queue drain: got %0d exp 0", q.size());
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule